// File: doc/BRIEF.md
# Region-of-interest readout buffer

This block sits behind a trigger processor and keeps the region-of-interest result of every crossing long enough for a level-1 decision to arrive. Each clock it takes in the per-crossing threshold-pass bits and the region coordinates. It stamps them with an internal 12-bit crossing number that wraps at a programmable orbit length. The stamped sample goes into a history ring. When the accept pulse comes, the block fetches the entry from a programmable number of clocks earlier. It adds a control flag and queues the record in a 16-entry FIFO.

Records leave as two 16-bit words over a valid/ready handshake. The first word of each record is marked with a frame-start signal. Each word carries an odd-parity bit in its top position. If an accept arrives while the FIFO is full, the accept is dropped and a sticky overflow flag is raised. Every record queued after that carries the control flag, so the receiver can tell that data went missing before it.

Top module: `roi_readout_buf`

## Requirements
- R1: An accept sampled at a clock edge captures the threshold bits and coordinates that were presented `latency` edges earlier, for every `latency` from 1 to 64.
- R2: The crossing counter is 0 after reset and advances once per clock. From any value at or above `orbitLen`-1 it returns to 0. Each record carries the counter value of the captured crossing in word 1 bits [11:0].
- R3: A record is two words. Word 0 is {parity, flag, coordinates[5:0], thresholds[7:0]}. Word 1 is {parity, 3'b000, crossing number[11:0]}.
- R4: Bit 15 of every word makes the count of ones in the 16-bit word odd.
- R5: While `outValid` is high and `outReady` is low, the word and `outFirst` hold steady on the next clock.
- R6: `outFirst` is high on word 0 of each record and low on word 1.
- R7: With the buffer empty, word 0 of a record is valid in the cycle after the accept edge. Records leave in accept order.
- R8: The FIFO holds 16 records. An accept that finds 16 records stored is dropped and leaves the stored records untouched. `overflow` then rises and stays high until reset.
- R9: The control flag (word 0 bit 14) equals the state of `overflow` at the edge that captured the record.
- R10: Accepts spaced 5 clocks apart with `outReady` held high never raise `overflow`, and every record comes out.
- R11: After reset, `outValid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one crossing per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| thrPass | input | 8 | Threshold-pass bits of the current crossing |
| roiCoord | input | 6 | Region coordinates of the current crossing |
| l1Accept | input | 1 | Level-1 accept pulse |
| latency | input | 7 | Accept latency in clocks, 1 to 64 |
| orbitLen | input | 12 | Number of crossings per orbit |
| outReady | input | 1 | Downstream accepts the current word |
| outValid | output | 1 | A word is on `outData` |
| outFirst | output | 1 | Current word is the first of a record |
| outData | output | 16 | Output word |
| overflow | output | 1 | Sticky flag: an accept was dropped |

## Verification
The accept pulse is registered into the FIFO at the edge that samples it. Word 0 therefore appears one cycle later, and each following word appears one cycle after a handshake edge. `overflow` rises at the same edge as the dropped accept. The bench model steps at each rising edge using the same sampled inputs, and the design outputs are compared against it at the falling edge that follows. Every latency and stall pattern is therefore judged in the cycle in which the result is due.

// File: rtl/roi_readout_pkg.sv
package roi_readout_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic push;      // write captured record into the FIFO
    logic pop;       // retire the FIFO head
    logic wordSel;   // 0: first word of head record, 1: second word
    logic lostFlag;  // control flag to store with the record
  } ctlStrobes_t;
endpackage

// File: rtl/roi_readout_dp.sv
module roi_readout_dp
  import roi_readout_pkg::*;
#(
  parameter int NUM_THR    = 8,
  parameter int COORD_W    = 6,
  parameter int BCN_W      = 12,
  parameter int MAX_LAT    = 64,
  parameter int FIFO_DEPTH = 16,
  localparam int LAT_W     = $clog2(MAX_LAT) + 1,
  localparam int WORD_W    = 2 + COORD_W + NUM_THR
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_THR-1:0] thrPass,
  input  logic [COORD_W-1:0] roiCoord,
  input  logic [LAT_W-1:0]   latency,
  input  logic [BCN_W-1:0]   orbitLen,
  input  ctlStrobes_t        strobes,
  output logic [WORD_W-1:0]  outData
);
  localparam int HIST_AW = $clog2(MAX_LAT);
  localparam int FIFO_AW = $clog2(FIFO_DEPTH);
  localparam int HIST_W  = NUM_THR + COORD_W + BCN_W;
  localparam int REC_W   = HIST_W + 1;
  localparam int PAD_W   = WORD_W - 1 - BCN_W;

  // crossing counter
  logic [BCN_W-1:0] bcnCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bcnCnt <= '0;
    else if (bcnCnt >= orbitLen - BCN_W'(1)) bcnCnt <= '0;
    else bcnCnt <= bcnCnt + BCN_W'(1);
  end

  // history ring: one entry per crossing
  logic [HIST_W-1:0]  histMem [MAX_LAT];
  logic [HIST_AW-1:0] histWp;
  logic [HIST_AW-1:0] histRp;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) histWp <= '0;
    else histWp <= histWp + HIST_AW'(1);
  end
  always_ff @(posedge clk) histMem[histWp] <= {thrPass, roiCoord, bcnCnt};
  assign histRp = histWp - latency[HIST_AW-1:0];

  // record FIFO storage and pointers
  logic [REC_W-1:0]   fifoMem [FIFO_DEPTH];
  logic [FIFO_AW-1:0] wrPtr, rdPtr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) wrPtr <= wrPtr + FIFO_AW'(1);
      if (strobes.pop)  rdPtr <= rdPtr + FIFO_AW'(1);
    end
  end
  always_ff @(posedge clk)
    if (strobes.push) fifoMem[wrPtr] <= {strobes.lostFlag, histMem[histRp]};

  // word formatting with odd parity
  logic [REC_W-1:0]   headRec;
  logic [NUM_THR-1:0] headThr;
  logic [COORD_W-1:0] headCoord;
  logic [BCN_W-1:0]   headBcn;
  logic [WORD_W-2:0]  wordBody;
  assign headRec   = fifoMem[rdPtr];
  assign headBcn   = headRec[BCN_W-1:0];
  assign headCoord = headRec[BCN_W +: COORD_W];
  assign headThr   = headRec[BCN_W + COORD_W +: NUM_THR];

  always_comb begin
    if (strobes.wordSel) wordBody = {{PAD_W{1'b0}}, headBcn};
    else                 wordBody = {headRec[REC_W-1], headCoord, headThr};
    outData = {~(^wordBody), wordBody};
  end

  AST_LAT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (latency != '0) && (latency <= LAT_W'(MAX_LAT)))
    else $error("latency outside 1..MAX_LAT"); // R1
endmodule

// File: rtl/roi_readout_ctl.sv
module roi_readout_ctl
  import roi_readout_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        l1Accept,
  input  logic        outReady,
  output ctlStrobes_t strobes,
  output logic        outValid,
  output logic        outFirst,
  output logic        overflow
);
  localparam int FIFO_AW = $clog2(FIFO_DEPTH);
  localparam logic [FIFO_AW:0] FULL_CNT = (FIFO_AW+1)'(FIFO_DEPTH);

  logic [FIFO_AW:0] count;
  logic             wordSel;
  logic             ovfReg;
  logic             full;
  logic             handshake;

  assign full      = (count == FULL_CNT);
  assign outValid  = (count != '0);
  assign handshake = outValid && outReady;
  assign outFirst  = outValid && !wordSel;
  assign overflow  = ovfReg;

  always_comb begin
    strobes.push     = l1Accept && !full;
    strobes.pop      = handshake && wordSel;
    strobes.wordSel  = wordSel;
    strobes.lostFlag = ovfReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      wordSel <= 1'b0;
      ovfReg  <= 1'b0;
    end else begin
      case ({strobes.push, strobes.pop})
        2'b10:   count <= count + (FIFO_AW+1)'(1);
        2'b01:   count <= count - (FIFO_AW+1)'(1);
        default: count <= count;
      endcase
      if (handshake) wordSel <= !wordSel;
      if (l1Accept && full) ovfReg <= 1'b1;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow) else $error("overflow cleared"); // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT) else $error("fifo count beyond depth"); // R8
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (full && !(outReady && wordSel)) |=> full) else $error("full fifo changed"); // R8
  AST_FRAME_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (outFirst && outReady) |=> (outValid && !outFirst)) else $error("word 1 missing"); // R6
endmodule

// File: rtl/roi_readout_buf.sv
module roi_readout_buf
  import roi_readout_pkg::*;
#(
  parameter int NUM_THR    = 8,
  parameter int COORD_W    = 6,
  parameter int BCN_W      = 12,
  parameter int MAX_LAT    = 64,
  parameter int FIFO_DEPTH = 16,
  localparam int LAT_W     = $clog2(MAX_LAT) + 1,
  localparam int WORD_W    = 2 + COORD_W + NUM_THR
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_THR-1:0] thrPass,
  input  logic [COORD_W-1:0] roiCoord,
  input  logic               l1Accept,
  input  logic [LAT_W-1:0]   latency,
  input  logic [BCN_W-1:0]   orbitLen,
  input  logic               outReady,
  output logic               outValid,
  output logic               outFirst,
  output logic [WORD_W-1:0]  outData,
  output logic               overflow
);
  ctlStrobes_t strobes;

  roi_readout_ctl #(.FIFO_DEPTH(FIFO_DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .l1Accept(l1Accept), .outReady(outReady),
    .strobes(strobes), .outValid(outValid), .outFirst(outFirst), .overflow(overflow)
  );

  roi_readout_dp #(
    .NUM_THR(NUM_THR), .COORD_W(COORD_W), .BCN_W(BCN_W),
    .MAX_LAT(MAX_LAT), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .thrPass(thrPass), .roiCoord(roiCoord),
    .latency(latency), .orbitLen(orbitLen), .strobes(strobes), .outData(outData)
  );

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outFirst)))
    else $error("word changed while stalled"); // R5
  AST_ODD_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (^outData)) else $error("even parity on word"); // R4
endmodule

// File: tb/roi_readout_buf_bench.sv
module roi_readout_buf_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  thrPass = '0;
  logic [5:0]  roiCoord = '0;
  logic        l1Accept = 1'b0;
  logic [6:0]  latency = 7'd5;
  logic [11:0] orbitLen = 12'd37;
  logic        outReady = 1'b1;
  logic        outValid, outFirst, overflow;
  logic [15:0] outData;

  int checks = 0;
  int errors = 0;
  bit randReady = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  roi_readout_buf u_roi_readout_buf (
    .clk(clk), .rstN(rstN), .thrPass(thrPass), .roiCoord(roiCoord),
    .l1Accept(l1Accept), .latency(latency), .orbitLen(orbitLen),
    .outReady(outReady), .outValid(outValid), .outFirst(outFirst),
    .outData(outData), .overflow(overflow)
  );

  // background crossing data and optional random ready
  always @(posedge clk) begin
    #2;
    thrPass  = 8'($urandom);
    roiCoord = 6'($urandom);
    if (randReady) outReady = 1'($urandom);
  end

  // ---------------- reference model ----------------
  logic [7:0]  hThr   [1024];
  logic [5:0]  hCoord [1024];
  logic [11:0] hBcn   [1024];
  logic [26:0] q[$];        // {flag, thr, coord, bcn}
  logic [26:0] newRec;
  bit   ovfM = 0, wsel = 0, doPush;
  int   bcnM = 0, cyc = 0, idx;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); ovfM = 0; wsel = 0; bcnM = 0; cyc = 0;
    end else begin
      doPush = 0;
      if (l1Accept) begin
        if (q.size() == 16) ovfM = 1;
        else begin
          idx = (cyc - int'(latency)) & 1023;
          newRec = {ovfM, hThr[idx], hCoord[idx], hBcn[idx]};
          doPush = 1;
        end
      end
      if (q.size() > 0 && outReady) begin
        if (wsel) begin wsel = 0; void'(q.pop_front()); end
        else wsel = 1;
      end
      if (doPush) q.push_back(newRec);
      hThr[cyc & 1023] = thrPass;
      hCoord[cyc & 1023] = roiCoord;
      hBcn[cyc & 1023] = 12'(bcnM);
      bcnM = (bcnM + 1 >= int'(orbitLen)) ? 0 : bcnM + 1;
      cyc++;
    end
  end

  function automatic logic [15:0] mkWord(logic [26:0] r, bit second);
    logic [14:0] body;
    body = second ? {3'b000, r[11:0]} : {r[26], r[17:12], r[25:18]};
    return {~(^body), body};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- per-cycle comparison ----------------
  bit stallPrev = 0;
  logic [15:0] dataPrev;
  logic [15:0] expWord;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(outValid == (q.size() > 0), "R7 outValid", outValid, q.size() > 0);
      chk(overflow == ovfM, "R8 overflow", overflow, ovfM);
      if (q.size() > 0) begin
        expWord = mkWord(q[0], wsel);
        chk(outFirst == !wsel, "R6 outFirst", outFirst, !wsel);
        chk(^outData == 1'b1, "R4 parity", outData, expWord);
        if (!wsel) begin
          chk(outData[13:0] == expWord[13:0], "R1 thr/coord", outData[13:0], expWord[13:0]);
          chk(outData[14] == expWord[14], "R9 flag", outData[14], expWord[14]);
        end else
          chk(outData[11:0] == expWord[11:0], "R2 bcn", outData[11:0], expWord[11:0]);
        chk(outData == expWord, "R3 word", outData, expWord);
      end
      if (stallPrev)
        chk(outValid && outData == dataPrev, "R5 hold", outData, dataPrev);
      stallPrev = outValid && !outReady;
      dataPrev  = outData;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask
  task automatic pulse();
    @(posedge clk); #2 l1Accept = 1'b1;
    @(posedge clk); #2 l1Accept = 1'b0;
  endtask
  task automatic spaced(int n);
    for (int i = 0; i < n; i++) begin pulse(); idle(3); end
  endtask

  int firstSeen;
  initial begin
    idle(3);
    @(negedge clk);
    chk(outValid == 0 && overflow == 0, "R11 reset state", {outValid, overflow}, 0);
    @(posedge clk); #2 rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 0 && overflow == 0, "R11 after release", {outValid, overflow}, 0);
    idle(80);
    // R7: single accept, first word one cycle after the accept edge
    @(posedge clk); #2 l1Accept = 1'b1;
    @(posedge clk); #2 l1Accept = 1'b0;
    @(negedge clk);
    chk(outValid && outFirst, "R7 latency of first word", {outValid, outFirst}, 3);
    idle(6);
    // R1: latency extremes
    @(posedge clk); #2 latency = 7'd1;
    spaced(4);
    @(posedge clk); #2 latency = 7'd64;
    spaced(4);
    @(posedge clk); #2 latency = 7'd17;
    // R5: random ready stalls
    randReady = 1;
    spaced(12);
    idle(60);
    randReady = 0;
    @(posedge clk); #2 outReady = 1'b1;
    idle(10);
    // R10: burst at minimum spacing
    spaced(30);
    idle(10);
    @(negedge clk);
    chk(overflow == 0 && outValid == 0, "R10 no loss at spacing 5", {overflow, outValid}, 0);
    // R8: fill with ready low, then overflow
    @(posedge clk); #2 outReady = 1'b0;
    spaced(16);
    @(negedge clk);
    chk(overflow == 0, "R8 sixteen stored", overflow, 0);
    spaced(3);
    @(negedge clk);
    chk(overflow == 1, "R8 overflow raised", overflow, 1);
    @(posedge clk); #2 outReady = 1'b1;
    idle(40);
    @(negedge clk);
    chk(outValid == 0, "R8 exactly sixteen drained", outValid, 0);
    // R9: record after a drop carries the flag
    pulse();
    firstSeen = 0;
    for (int i = 0; i < 4 && !firstSeen; i++) begin
      @(negedge clk);
      if (outValid && outFirst) begin
        firstSeen = 1;
        chk(outData[14] == 1'b1, "R9 flag after drop", outData[14], 1);
      end
    end
    chk(firstSeen == 1, "R9 record present", firstSeen, 1);
    idle(8);
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R7 watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule